// File: doc/BRIEF.md
# LIN Bus Remote Wake-Up Detector

This block qualifies remote wake-up requests on a set of independent LIN buses. Each channel receives the digitised level of its bus, where 0 means dominant, and registers it through a two-flop synchroniser. A request is accepted only when the bus has stayed dominant for a minimum filter time and then returns to recessive. After that recessive edge a short settling delay runs, and the channel then emits a one-clock wake pulse on its own output bit. The controller therefore knows which bus woke.

All timing is counted in ticks of a shared microsecond strobe. A single detect-enable from the mode controller arms every channel. The controller raises it during sleep and during the filtering window of a normal-to-sleep transition. While the enable is low, every dominant counter is cleared and every pending request is dropped. The filter length defaults to 90 ticks and the settling delay to 3 ticks; both are parameters. The default channel count is four.

Top module: `lin_wake_detect`

## Requirements
- R1: After reset every `wake_o` bit is 0, and each synchroniser holds the recessive level (1).
- R2: A bus held dominant for more than `FILT_TICKS` ticks and then released to recessive produces exactly one `wake_o` pulse on that channel's bit, one clock wide.
- R3: A dominant interval that ends before `FILT_TICKS` ticks have been counted produces no pulse. A later recessive level does not resume the count.
- R4: A bus that stays dominant produces no pulse however long it stays low, and the dominant count saturates at `FILT_TICKS`. Releasing the bus afterwards still produces one pulse.
- R5: The recessive level reaches the qualifier two clocks after it appears at `bus_i`. The pulse then appears one clock after the `SETTLE_TICKS`-th tick that follows the cycle in which the qualified edge is seen.
- R6: While `det_en_i` is 0, no pulse is issued and the dominant count is held at zero. Dropping `det_en_i` during the settling delay cancels the pending request. Dominant time that passes while the enable is low does not count toward qualification.
- R7: Bit c of `wake_o` depends only on bit c of `bus_i`. Channels qualify and fire independently, and can fire at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick_i | input | 1 | One-clock strobe once per microsecond |
| det_en_i | input | 1 | Wake detection enable from the mode controller |
| bus_i | input | NCH | Sampled bus level per channel, 0 = dominant |
| wake_o | output | NCH | Registered one-clock wake pulse per channel |

## Verification
Long dominant intervals on one channel, with the others idle, separate a correct wake from cross-talk between channels. Short dominant intervals show that the bus level alone never wakes the block and that the count restarts. A bus held dominant for several filter lengths exercises saturation and the stuck-bus case. Dropping the enable during the settling delay, and holding the bus dominant across an enable rise, show cancellation and clearing. Two channels released at different times show independent firing. A per-clock reference model checks the exact pulse cycle.

// File: rtl/lwk_pkg.sv
package lwk_pkg;
  typedef enum logic [0:0] {
    SETL_IDLE = 1'b0,
    SETL_RUN  = 1'b1
  } settle_state_t;
endpackage

// File: rtl/lwk_sync2.sv
module lwk_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic meta_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/lwk_dom_timer.sv
module lwk_dom_timer #(
  parameter int FILT_TICKS = 90
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic tick_i,
  input  logic lvl_i,
  output logic qual_o
);
  localparam int CW = $clog2(FILT_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(FILT_TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i || lvl_i) begin
      cnt_q <= '0;
    end else if (tick_i && cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign qual_o = (cnt_q == LIMIT);

  // R4
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT);

  // R6
  cnt_clr_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> cnt_q == '0);

  // R3
  qual_dom_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(qual_o) |-> $past(!lvl_i));
endmodule

// File: rtl/lwk_settle.sv
module lwk_settle
  import lwk_pkg::*;
#(
  parameter int SETTLE_TICKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic tick_i,
  input  logic fire_i,
  output logic wake_o
);
  localparam int DW = $clog2(SETTLE_TICKS + 1);
  localparam logic [DW-1:0] LAST = DW'(SETTLE_TICKS - 1);

  settle_state_t st_q;
  logic [DW-1:0] dcnt_q;
  logic          done;

  assign done = (st_q == SETL_RUN) && tick_i && (dcnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      st_q   <= SETL_IDLE;
      dcnt_q <= '0;
    end else if (fire_i) begin
      st_q   <= SETL_RUN;
      dcnt_q <= '0;
    end else if (st_q == SETL_RUN && tick_i) begin
      if (dcnt_q == LAST) begin
        st_q <= SETL_IDLE;
      end else begin
        dcnt_q <= dcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_o <= 1'b0;
    end else begin
      wake_o <= en_i && done;
    end
  end

  // R6
  no_wake_dis_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !wake_o);

  // R2
  one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    wake_o |=> !wake_o);

  // R5
  wake_after_run_chk: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> $past(st_q == SETL_RUN));
endmodule

// File: rtl/lin_wake_detect.sv
module lin_wake_detect #(
  parameter int NCH          = 4,
  parameter int FILT_TICKS   = 90,
  parameter int SETTLE_TICKS = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           us_tick_i,
  input  logic           det_en_i,
  input  logic [NCH-1:0] bus_i,
  output logic [NCH-1:0] wake_o
);
  logic [NCH-1:0] lvl_s;
  logic [NCH-1:0] qual_s;
  logic [NCH-1:0] fire_s;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    lwk_sync2 #(.RST_VAL(1'b1)) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i (bus_i[c]),
      .q_o (lvl_s[c])
    );

    lwk_dom_timer #(.FILT_TICKS(FILT_TICKS)) u_timer (
      .clk    (clk),
      .rst    (rst),
      .en_i   (det_en_i),
      .tick_i (us_tick_i),
      .lvl_i  (lvl_s[c]),
      .qual_o (qual_s[c])
    );

    assign fire_s[c] = det_en_i && lvl_s[c] && qual_s[c];

    lwk_settle #(.SETTLE_TICKS(SETTLE_TICKS)) u_settle (
      .clk    (clk),
      .rst    (rst),
      .en_i   (det_en_i),
      .tick_i (us_tick_i),
      .fire_i (fire_s[c]),
      .wake_o (wake_o[c])
    );
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    rst |=> wake_o == '0);
endmodule

// File: tb/lin_wake_detect_tb.sv
module lin_wake_detect_tb;
  localparam int NCH = 4;
  localparam int FILT = 90;
  localparam int SETL = 3;
  localparam int TPER = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic us_tick_i = 1'b0;
  logic det_en_i = 1'b0;
  logic [NCH-1:0] bus_i = '1;
  logic [NCH-1:0] wake_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int wcount [NCH];
  bit done = 0;

  // reference model state
  int m_s1 [NCH];
  int m_s2 [NCH];
  int m_dom [NCH];
  int m_busy [NCH];
  int m_dcnt [NCH];
  bit exp_w [NCH];

  lin_wake_detect #(.NCH(NCH), .FILT_TICKS(FILT), .SETTLE_TICKS(SETL)) u_dut (
    .clk(clk), .rst(rst), .us_tick_i(us_tick_i), .det_en_i(det_en_i),
    .bus_i(bus_i), .wake_o(wake_o)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    us_tick_i <= ((cyc % TPER) == TPER - 1);
  end

  // behavioural reference, one update per clock
  always @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (rst) begin
        m_s1[c] = 1; m_s2[c] = 1; m_dom[c] = 0;
        m_busy[c] = 0; m_dcnt[c] = 0; exp_w[c] = 0;
      end else begin
        int lvl;
        lvl = m_s2[c];
        exp_w[c] = det_en_i && m_busy[c] != 0 && us_tick_i && m_dcnt[c] == SETL - 1;
        if (!det_en_i) begin
          m_busy[c] = 0; m_dcnt[c] = 0;
        end else if (lvl == 1 && m_dom[c] >= FILT) begin
          m_busy[c] = 1; m_dcnt[c] = 0;
        end else if (m_busy[c] != 0 && us_tick_i) begin
          if (m_dcnt[c] == SETL - 1) m_busy[c] = 0;
          else m_dcnt[c] = m_dcnt[c] + 1;
        end
        if (!det_en_i || lvl == 1) m_dom[c] = 0;
        else if (us_tick_i && m_dom[c] < FILT) m_dom[c] = m_dom[c] + 1;
        m_s2[c] = m_s1[c];
        m_s1[c] = int'(bus_i[c]);
      end
    end
  end

  // per-clock compare (R5, R7 exact timing per channel)
  always @(negedge clk) begin
    if (!rst) begin
      for (int c = 0; c < NCH; c++) begin
        n_cmp++;
        if (wake_o[c] !== exp_w[c]) begin
          n_bad++;
          $display("FAIL R5/R7 ch%0d cycle %0d: wake=%b expected %b", c, cyc, wake_o[c], exp_w[c]);
        end
        if (wake_o[c] === 1'b1) wcount[c]++;
      end
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_counts();
    for (int c = 0; c < NCH; c++) wcount[c] = 0;
  endtask

  task automatic chk_count(string req, int c, int expv);
    n_cmp++;
    if (wcount[c] != expv) begin
      n_bad++;
      $display("FAIL %s ch%0d pulse count: got %0d expected %0d", req, c, wcount[c], expv);
    end
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) wcount[c] = 0;
    wait_clk(5);
    // R1: reset state
    n_cmp++;
    if (wake_o !== '0) begin
      n_bad++;
      $display("FAIL R1 wake after reset: got %b expected 0000", wake_o);
    end
    rst = 1'b0;
    det_en_i = 1'b1;
    wait_clk(10);

    // R2: long dominant on ch0 then release
    clr_counts();
    bus_i[0] = 1'b0; wait_clk(100 * TPER);
    bus_i[0] = 1'b1; wait_clk(40);
    chk_count("R2", 0, 1);
    chk_count("R7", 1, 0);
    chk_count("R7", 2, 0);
    chk_count("R7", 3, 0);

    // R5: latency from release to pulse within the tick window
    begin
      int lat;
      bus_i[0] = 1'b0; wait_clk(100 * TPER);
      bus_i[0] = 1'b1; lat = 0;
      while (wake_o[0] !== 1'b1 && lat < 100) begin wait_clk(1); lat++; end
      n_cmp++;
      if (lat < 2 + (SETL - 1) * TPER || lat > 3 + SETL * TPER) begin
        n_bad++;
        $display("FAIL R5 latency: got %0d expected %0d..%0d", lat, 2 + (SETL - 1) * TPER, 3 + SETL * TPER);
      end
      wait_clk(20);
    end

    // R3: short dominant, twice, separated by recessive
    clr_counts();
    bus_i[1] = 1'b0; wait_clk(50 * TPER);
    bus_i[1] = 1'b1; wait_clk(10);
    bus_i[1] = 1'b0; wait_clk(50 * TPER);
    bus_i[1] = 1'b1; wait_clk(40);
    chk_count("R3", 1, 0);

    // R4: stuck dominant, then release
    clr_counts();
    bus_i[2] = 1'b0; wait_clk(300 * TPER);
    chk_count("R4", 2, 0);
    bus_i[2] = 1'b1; wait_clk(40);
    chk_count("R4", 2, 1);

    // R6: enable dropped during the settling delay
    clr_counts();
    bus_i[3] = 1'b0; wait_clk(100 * TPER);
    bus_i[3] = 1'b1; wait_clk(4);
    det_en_i = 1'b0; wait_clk(30);
    det_en_i = 1'b1; wait_clk(40);
    chk_count("R6", 3, 0);

    // R6: dominant time while disabled does not count
    clr_counts();
    det_en_i = 1'b0;
    bus_i[0] = 1'b0; wait_clk(80 * TPER);
    det_en_i = 1'b1; wait_clk(40 * TPER);
    bus_i[0] = 1'b1; wait_clk(40);
    chk_count("R6", 0, 0);

    // R6: no pulse while disabled even after long dominant
    clr_counts();
    det_en_i = 1'b0;
    bus_i[1] = 1'b0; wait_clk(120 * TPER);
    bus_i[1] = 1'b1; wait_clk(40);
    chk_count("R6", 1, 0);
    det_en_i = 1'b1; wait_clk(10);

    // R7: two channels at once, released at different times
    clr_counts();
    bus_i[0] = 1'b0; bus_i[3] = 1'b0; wait_clk(95 * TPER);
    bus_i[3] = 1'b1; wait_clk(20 * TPER);
    bus_i[0] = 1'b1; wait_clk(40);
    chk_count("R7", 0, 1);
    chk_count("R7", 3, 1);
    chk_count("R7", 1, 0);
    chk_count("R7", 2, 0);

    // R7: all channels simultaneously
    clr_counts();
    bus_i = '0; wait_clk(100 * TPER);
    bus_i = '1; wait_clk(40);
    for (int c = 0; c < NCH; c++) chk_count("R7", c, 1);

    done = 1;
  end

  initial begin
    while (!done && cyc < 150000) @(negedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: cycle %0d expected completion", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule